// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches a recovered unipolar bit stream. Each bit is presented with a one-cycle enable, and a mark is 1 while a space is 0. A long unbroken run of spaces raises an alarm. The alarm drops again only when the stream has recovered two things: enough marks across a sliding window, and no over-long space run inside that window. A synchronous clear command forces the alarm off and restarts every counter.

A second function picks which clock enable drives the receive clock output. While the alarm is off, the recovered clock is used. While it is on, the local reference is used, or a crystal-derived fallback when the reference is reported absent. The source only changes in a cycle where the outgoing and incoming enables are both low, so the output never carries a shortened pulse. A one-cycle change pulse marks every edge of the alarm so that an interrupt latch can capture it.

The alarm logic is a two-state machine:
- States: `ST_MONITOR` (no alarm) and `ST_ALARM`.
- Transitions: lose (`ST_MONITOR` to `ST_ALARM` on the run limit), recover (`ST_ALARM` to `ST_MONITOR` when the density and gap tests pass), and clear (any state to `ST_MONITOR` on the clear command).

The clock selector is a three-state machine with states `SRC_REC`, `SRC_REF` and `SRC_XTAL`. Its only transition is a switch to the wanted source, taken when both enables are low.

Top module: `los_monitor`

## Requirements
- R1: After reset `los` and `los_change` are 0 and `rclk_en_out` follows `rec_clk_en`.
- R2: The space-run counter counts accepted spaces and returns to 0 on an accepted mark. `los` rises on the edge that accepts the RUN_LIMIT-th consecutive space (default 175), and not one bit earlier.
- R3: `bit_in` has no effect in cycles where `bit_en` is 0.
- R4: While alarmed, `los` falls on the edge that accepts a bit completing both tests over the last WIN accepted bits (default 32). Those bits must hold at least MIN_MARKS marks (default 4). None of them may be a space that ends an unbroken space run longer than MAX_GAP (default 15).
- R5: A window holding enough marks but also a space run longer than MAX_GAP keeps `los` at 1.
- R6: A window with gaps no longer than MAX_GAP but fewer than MIN_MARKS marks keeps `los` at 1.
- R7: A cycle with `clear_cmd` at 1 sets `los` to 0 on the next edge and restarts the space run and window, so a fresh RUN_LIMIT spaces are needed to alarm again. The clear command has priority over `bit_en`.
- R8: `los_change` is 1 for exactly the one cycle in which `los` differs from its value in the previous cycle.
- R9: The wanted source is set as follows. With `los` at 0 it is the recovered enable. With `los` at 1 and `ref_present` at 1 it is `ref_clk_en`. With `los` at 1 and `ref_present` at 0 it is `xtal_clk_en`. `rclk_en_out` equals the enable of the currently selected source.
- R10: The selected source changes only on an edge where the enables of both the current and the wanted source are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_cmd | input | 1 | Synchronous clear of alarm and counters |
| bit_en | input | 1 | Recovered-bit enable |
| bit_in | input | 1 | Recovered bit, 1 = mark |
| ref_present | input | 1 | Local reference clock is available |
| rec_clk_en | input | 1 | Recovered clock enable |
| ref_clk_en | input | 1 | Local reference clock enable |
| xtal_clk_en | input | 1 | Crystal-derived fallback clock enable |
| los | output | 1 | Loss-of-signal alarm |
| los_change | output | 1 | One-cycle pulse on each alarm edge |
| rclk_en_out | output | 1 | Selected receive clock enable |

## Verification
The bench builds the block with its default parameters: a 175-space alarm run, a 32-bit window, 4 marks and a 15-space gap bound. These values are small enough that every alarm entry, every blocked exit and every successful exit is driven to the exact bit that decides it. The three clock enables run with periods of 4, 6 and 5 cycles. This gives both quiet slots, where a switch may happen, and busy slots, where it must wait. Each switch between all three sources is therefore compared against the reference model on every cycle.

// File: rtl/los_mon_pkg.sv
package los_mon_pkg;

    typedef enum logic {
        ST_MONITOR = 1'b0,
        ST_ALARM   = 1'b1
    } los_state_e;

    typedef enum logic [1:0] {
        SRC_REC  = 2'd0,
        SRC_REF  = 2'd1,
        SRC_XTAL = 2'd2
    } clk_src_e;

endpackage

// File: rtl/los_run_counter.sv
module los_run_counter #(
    parameter int RUN_LIMIT = 175,
    parameter int RW        = $clog2(RUN_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_en,
    input  logic          bit_in,
    output logic [RW-1:0] run_q,
    output logic [RW-1:0] run_nxt
);
    localparam logic [RW-1:0] RUN_LIM = RW'(RUN_LIMIT);

    always_comb begin
        run_nxt = run_q;
        if (clr) begin
            run_nxt = '0;
        end else if (bit_en) begin
            if (bit_in)
                run_nxt = '0;
            else if (run_q != RUN_LIM)
                run_nxt = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_nxt;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clr) |=> $stable(run_q));

endmodule

// File: rtl/los_density_window.sv
module los_density_window #(
    parameter int WIN     = 32,
    parameter int MAX_GAP = 15,
    parameter int RW      = 8,
    parameter int CW      = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_en,
    input  logic          bit_in,
    input  logic [RW-1:0] run_nxt,
    output logic [CW-1:0] ones_q,
    output logic [CW-1:0] ones_nxt,
    output logic [CW-1:0] clean_q,
    output logic [CW-1:0] clean_nxt
);
    localparam logic [CW-1:0] WIN_LIM = CW'(WIN);
    localparam logic [RW-1:0] GAP_LIM = RW'(MAX_GAP);

    logic [WIN-1:0] win_q;
    logic [WIN-1:0] win_nxt;
    logic           leaving;
    logic           bad_bit;

    assign leaving = win_q[WIN-1];
    assign bad_bit = !bit_in && (run_nxt > GAP_LIM);

    always_comb begin
        win_nxt   = win_q;
        ones_nxt  = ones_q;
        clean_nxt = clean_q;
        if (clr) begin
            win_nxt   = '0;
            ones_nxt  = '0;
            clean_nxt = '0;
        end else if (bit_en) begin
            win_nxt  = {win_q[WIN-2:0], bit_in};
            ones_nxt = ones_q + CW'(bit_in) - CW'(leaving);
            if (bad_bit)
                clean_nxt = '0;
            else if (clean_q != WIN_LIM)
                clean_nxt = clean_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            ones_q  <= '0;
            clean_q <= '0;
        end else begin
            win_q   <= win_nxt;
            ones_q  <= ones_nxt;
            clean_q <= clean_nxt;
        end
    end

    // R6
    ones_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= WIN_LIM);

    // R5
    gap_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !bit_in && run_nxt > GAP_LIM) |=> (clean_q == '0));

endmodule

// File: rtl/los_alarm_fsm.sv
module los_alarm_fsm
    import los_mon_pkg::*;
#(
    parameter int RUN_LIMIT = 175,
    parameter int WIN       = 32,
    parameter int MIN_MARKS = 4,
    parameter int RW        = 8,
    parameter int CW        = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_en,
    input  logic [RW-1:0] run_q,
    input  logic [RW-1:0] run_nxt,
    input  logic [CW-1:0] ones_q,
    input  logic [CW-1:0] ones_nxt,
    input  logic [CW-1:0] clean_q,
    input  logic [CW-1:0] clean_nxt,
    output logic          los,
    output logic          los_chg
);
    localparam logic [RW-1:0] RUN_LIM  = RW'(RUN_LIMIT);
    localparam logic [CW-1:0] WIN_LIM  = CW'(WIN);
    localparam logic [CW-1:0] ONES_LIM = CW'(MIN_MARKS);

    los_state_e state_q, state_d;
    logic       chg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MONITOR: begin
                if (!clr && bit_en && run_nxt == RUN_LIM)
                    state_d = ST_ALARM;
            end
            ST_ALARM: begin
                if (clr)
                    state_d = ST_MONITOR;
                else if (bit_en && ones_nxt >= ONES_LIM && clean_nxt == WIN_LIM)
                    state_d = ST_MONITOR;
            end
            default: state_d = ST_MONITOR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MONITOR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= (state_d != state_q);
    end

    assign los     = (state_q == ST_ALARM);
    assign los_chg = chg_q;

    // R2
    alarm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> (run_q == RUN_LIM));

    // R4
    alarm_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> ($past(clr) || (clean_q == WIN_LIM && ones_q >= ONES_LIM)));

    // R8
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los_chg |-> (los != $past(los)));

endmodule

// File: rtl/los_clk_select.sv
module los_clk_select
    import los_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic los,
    input  logic ref_present,
    input  logic rec_en,
    input  logic ref_en,
    input  logic xtal_en,
    output logic rclk_out
);
    clk_src_e sel_q, sel_d, want;

    function automatic logic src_en(input clk_src_e s, input logic a,
                                    input logic b, input logic c);
        logic r;
        unique case (s)
            SRC_REC:  r = a;
            SRC_REF:  r = b;
            SRC_XTAL: r = c;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    always_comb begin
        if (!los)             want = SRC_REC;
        else if (ref_present) want = SRC_REF;
        else                  want = SRC_XTAL;
    end

    always_comb begin
        sel_d = sel_q;
        unique case (sel_q)
            SRC_REC, SRC_REF, SRC_XTAL: begin
                if (want != sel_q
                    && !src_en(sel_q, rec_en, ref_en, xtal_en)
                    && !src_en(want, rec_en, ref_en, xtal_en))
                    sel_d = want;
            end
            default: sel_d = SRC_REC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SRC_REC;
        else        sel_q <= sel_d;
    end

    always_comb begin
        rclk_out = src_en(sel_q, rec_en, ref_en, xtal_en);
    end

    // R10
    switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> ($past(rclk_out) == 1'b0));

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
    parameter int RUN_LIMIT = 175,
    parameter int WIN       = 32,
    parameter int MIN_MARKS = 4,
    parameter int MAX_GAP   = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_cmd,
    input  logic bit_en,
    input  logic bit_in,
    input  logic ref_present,
    input  logic rec_clk_en,
    input  logic ref_clk_en,
    input  logic xtal_clk_en,
    output logic los,
    output logic los_change,
    output logic rclk_en_out
);
    localparam int RW = $clog2(RUN_LIMIT + 1);
    localparam int CW = $clog2(WIN + 1);

    logic [RW-1:0] run_q, run_nxt;
    logic [CW-1:0] ones_q, ones_nxt, clean_q, clean_nxt;
    logic          los_i;

    los_run_counter #(.RUN_LIMIT(RUN_LIMIT), .RW(RW)) u_run (
        .clk(clk), .rst_n(rst_n), .clr(clear_cmd), .bit_en(bit_en),
        .bit_in(bit_in), .run_q(run_q), .run_nxt(run_nxt)
    );

    los_density_window #(.WIN(WIN), .MAX_GAP(MAX_GAP), .RW(RW), .CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(clear_cmd), .bit_en(bit_en),
        .bit_in(bit_in), .run_nxt(run_nxt), .ones_q(ones_q),
        .ones_nxt(ones_nxt), .clean_q(clean_q), .clean_nxt(clean_nxt)
    );

    los_alarm_fsm #(.RUN_LIMIT(RUN_LIMIT), .WIN(WIN), .MIN_MARKS(MIN_MARKS),
                    .RW(RW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clear_cmd), .bit_en(bit_en),
        .run_q(run_q), .run_nxt(run_nxt), .ones_q(ones_q),
        .ones_nxt(ones_nxt), .clean_q(clean_q), .clean_nxt(clean_nxt),
        .los(los_i), .los_chg(los_change)
    );

    los_clk_select u_sel (
        .clk(clk), .rst_n(rst_n), .los(los_i), .ref_present(ref_present),
        .rec_en(rec_clk_en), .ref_en(ref_clk_en), .xtal_en(xtal_clk_en),
        .rclk_out(rclk_en_out)
    );

    assign los = los_i;

endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
    localparam int RUN_LIMIT = 175;
    localparam int WIN       = 32;
    localparam int MIN_MARKS = 4;
    localparam int MAX_GAP   = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_cmd = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic ref_present = 1'b1;
    logic rec_clk_en = 1'b0;
    logic ref_clk_en = 1'b0;
    logic xtal_clk_en = 1'b0;
    logic los, los_change, rclk_en_out;

    int vectors = 0;
    int miscompares = 0;
    int chg_seen = 0;
    int cyc = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    bit m_los = 1'b0;
    bit m_chg = 1'b0;
    int m_sel = 0;
    int m_run = 0;
    bit m_bits[$];
    int m_runs[$];

    always #5 clk = ~clk;

    los_monitor #(.RUN_LIMIT(RUN_LIMIT), .WIN(WIN), .MIN_MARKS(MIN_MARKS),
                  .MAX_GAP(MAX_GAP)) u_los_monitor (
        .clk(clk), .rst_n(rst_n), .clear_cmd(clear_cmd), .bit_en(bit_en),
        .bit_in(bit_in), .ref_present(ref_present), .rec_clk_en(rec_clk_en),
        .ref_clk_en(ref_clk_en), .xtal_clk_en(xtal_clk_en), .los(los),
        .los_change(los_change), .rclk_en_out(rclk_en_out)
    );

    task automatic check(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit en_of(input int s);
        if (s == 0) return rec_clk_en;
        if (s == 1) return ref_clk_en;
        return xtal_clk_en;
    endfunction

    // clock-source enable patterns
    always @(posedge clk) begin
        #1;
        cyc++;
        rec_clk_en  = (cyc % 4 == 0);
        ref_clk_en  = (cyc % 6 < 2);
        xtal_clk_en = (cyc % 5 == 1);
    end

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_los = 0; m_chg = 0; m_sel = 0; m_run = 0;
            m_bits.delete(); m_runs.delete();
        end else begin
            int want;
            bit prev;
            want = !m_los ? 0 : (ref_present ? 1 : 2);
            if (want != m_sel && !en_of(m_sel) && !en_of(want)) m_sel = want;
            prev = m_los;
            if (clear_cmd) begin
                m_los = 0; m_run = 0;
                m_bits.delete(); m_runs.delete();
            end else if (bit_en) begin
                int ones;
                bit gap_ok;
                m_run = bit_in ? 0 : ((m_run < RUN_LIMIT) ? m_run + 1 : RUN_LIMIT);
                m_bits.push_back(bit_in);
                m_runs.push_back(bit_in ? 0 : m_run);
                if (m_bits.size() > WIN) begin
                    void'(m_bits.pop_front());
                    void'(m_runs.pop_front());
                end
                ones = 0; gap_ok = 1;
                foreach (m_bits[i]) ones += m_bits[i];
                foreach (m_runs[i]) if (m_runs[i] > MAX_GAP) gap_ok = 0;
                if (!m_los && m_run >= RUN_LIMIT) m_los = 1;
                else if (m_los && m_bits.size() == WIN && ones >= MIN_MARKS && gap_ok)
                    m_los = 0;
            end
            m_chg = (m_los != prev);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(los, m_los, "R2 R4 R5 R6 R7 los");
            check(los_change, m_chg, "R8 los_change");
            check(rclk_en_out, en_of(m_sel), "R9 R10 rclk_en_out");
            if (los_change) chg_seen++;
        end
    end

    task automatic send(input bit b);
        bit_en = 1'b1; bit_in = b;
        @(posedge clk); #1;
        bit_en = 1'b0; bit_in = ~b;   // noise while disabled (R3)
        @(posedge clk); #1;
    endtask

    task automatic send_n(input bit b, input int n);
        for (int i = 0; i < n; i++) send(b);
    endtask

    task automatic group(input int marks, input int spaces, input int reps);
        for (int r = 0; r < reps; r++) begin
            send_n(1'b1, marks);
            send_n(1'b0, spaces);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int c0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(los, 0, "R1 los after reset");
        check(los_change, 0, "R1 los_change after reset");
        rst_n = 1'b1;
        started = 1'b1;
        @(posedge clk); #1;

        // R2 / R3: exact alarm threshold with noise on disabled cycles
        send_n(1'b0, RUN_LIMIT - 1);
        check(los, 0, "R2 one space short of limit");
        c0 = chg_seen;
        send(1'b0);
        check(los, 1, "R2 alarm at limit");
        check(chg_seen - c0, 1, "R8 single pulse on rise");

        // R9 source choice while alarmed
        wait_cyc(20);
        @(negedge clk);
        check(rclk_en_out, ref_clk_en, "R9 reference source");
        ref_present = 1'b0;
        wait_cyc(20);
        @(negedge clk);
        check(rclk_en_out, xtal_clk_en, "R9 fallback source");
        @(posedge clk); #1;
        ref_present = 1'b1;

        // R6: gaps short, too few marks
        group(1, 10, 6);
        check(los, 1, "R6 sparse marks keep alarm");
        // R4: 1 mark per 8 bits recovers
        c0 = chg_seen;
        group(1, 7, 6);
        check(los, 0, "R4 recovered");
        check(chg_seen - c0, 1, "R8 single pulse on fall");
        wait_cyc(20);
        @(negedge clk);
        check(rclk_en_out, rec_clk_en, "R9 back to recovered");
        @(posedge clk); #1;

        // R2: a mark restarts the run
        send_n(1'b0, 100);
        send(1'b1);
        send_n(1'b0, RUN_LIMIT - 1);
        check(los, 0, "R2 mark restarted run");
        send(1'b0);
        check(los, 1, "R2 alarm after restart");

        // R5: dense marks but 16-space gaps
        group(4, 16, 4);
        check(los, 1, "R5 long gap keeps alarm");
        group(4, 15, 3);
        check(los, 0, "R4 recovered with gaps at bound");

        // R7: clear command
        send_n(1'b0, RUN_LIMIT);
        check(los, 1, "R7 alarm before clear");
        c0 = chg_seen;
        clear_cmd = 1'b1; bit_en = 1'b1; bit_in = 1'b0;
        @(posedge clk); #1;
        clear_cmd = 1'b0; bit_en = 1'b0;
        check(los, 0, "R7 clear drops alarm");
        @(posedge clk); #1;
        check(chg_seen - c0, 1, "R8 pulse on clear");
        send_n(1'b0, RUN_LIMIT - 1);
        check(los, 0, "R7 run restarted by clear");
        c0 = chg_seen;
        clear_cmd = 1'b1;
        @(posedge clk); #1;
        clear_cmd = 1'b0;
        @(posedge clk); #1;
        check(chg_seen - c0, 0, "R8 no pulse when clear while idle");
        send_n(1'b0, RUN_LIMIT - 1);
        check(los, 0, "R7 run restarted again");
        send(1'b0);
        check(los, 1, "R7 alarm after fresh run");
        wait_cyc(10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule